// File: doc/BRIEF.md
# Translation Buffer Pointer Generator

This block helps a software miss handler locate the entry it needs in an in-memory table of translations. Software first loads a tag register with the missing virtual page and its 13-bit context. It also loads four table base registers, one for each pair of context class (context zero or any other context) and page-size slot (0 or 1), and two configuration registers that carry the page-size code. Reading a pointer code then returns a ready-made, 16-byte-aligned entry address. The block chooses the base and configuration by context class, shifts the faulting address right by an amount set by the page-size code, and keeps only as many index bits as the table-size field of the base allows.

A second read view, the tag target, repacks the tag register so that it can be compared directly with a stored table entry. Register writes use a plain strobe with a code and data. Reads are a valid/ready request stream that feeds a one-deep response register, and the response is also valid/ready. A read is accepted when `rd_valid` and `rd_ready` are both high. `rd_ready` is high whenever the response register is empty or is being drained in the same cycle. While `rsp_valid` is high and `rsp_ready` is low, the response holds its value.

Top module: `tsbp_gen`

## Requirements
- R1: After reset every register is zero, `rsp_valid` is low and `rd_ready` is high, so every read code returns zero.
- R2: A write strobe stores `wr_data` into the register named by `wr_sel`: 0 tag, 4 base zero-context slot 0, 5 base zero-context slot 1, 6 base other-context slot 0, 7 base other-context slot 1, 8 config zero-context, 9 config other-context. A read of the same code returns the stored value.
- R3: Writes to codes 1, 2, 3 and 10 to 15 change no register. Reads of codes 10 to 15 return zero.
- R4: When tag bits 12:0 are all zero, the pointers use codes 4, 5 and 8. Otherwise they use codes 6, 7 and 9.
- R5: The slot 0 pointer (read code 2) is built from two parts. The first is the selected base with bits 12:0 cleared. The second is the tag shifted right by 9+3*P, where P is config bits 2:0, and it is kept only in bits 4 through 12+S, where S is base bits 3:0. The two parts are ORed together.
- R6: The slot 1 pointer (read code 3) follows the same rule with the slot 1 base. When that base has bit 12 set, bit 13+S of the pointer is also set. Bit 12 of the slot 0 base has no effect on the slot 0 pointer.
- R7: The tag target view (read code 1) places tag bits 63:22 in result bits 41:0 and tag bits 12:0 in result bits 60:48. All other bits are zero.
- R8: An accepted read presents `rsp_valid` with its data on the next cycle.
- R9: While `rsp_valid` is high and `rsp_ready` is low, `rsp_data` holds steady and `rd_ready` is low, even if a register is written meanwhile.
- R10: Reads, including pointer reads, do not change any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 4 | Register code for the write |
| wr_data | input | 64 | Write data |
| rd_valid | input | 1 | Read request valid |
| rd_ready | output | 1 | Read request can be accepted |
| rd_sel | input | 4 | Register code for the read |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Consumer accepts the response |
| rsp_data | output | 64 | Read response data |

## Verification
The assertions assume that reset is held low for at least one clock edge before traffic starts. They also assume that every input is at a known level at each edge, since the context-class and stability checks compare register contents cycle by cycle. The stimulus changes inputs only on falling edges, releases reset before the first request, and never raises a write and a read in the same cycle. The one exception is the stall test, which writes the tag on purpose while a response is held, to show that the held response stays untouched.

// File: rtl/tsbp_pkg.sv
package tsbp_pkg;
  localparam int DATA_W      = 64;
  localparam int SEL_W       = 4;
  localparam int CTX_W       = 13;
  localparam int VPN_LO      = 13;
  localparam int TGT_VA_LO   = 22;
  localparam int TGT_CTX_POS = 48;
  localparam int IDX_LO      = 4;
  localparam int IDX_HI_BASE = 12;
  localparam int SHIFT_BASE  = 9;
  localparam int SHIFT_STEP  = 3;
  localparam int PS_W        = 3;
  localparam int SZ_W        = 4;
  localparam int SPLIT_BIT   = 12;
  localparam int N_CLASS     = 2;
  localparam int N_SLOT      = 2;
  localparam int TGT_VA_W    = DATA_W - TGT_VA_LO;

  typedef enum logic [SEL_W-1:0] {
    SEL_TAG   = 4'd0,
    SEL_TGT   = 4'd1,
    SEL_PTR0  = 4'd2,
    SEL_PTR1  = 4'd3,
    SEL_B_Z0  = 4'd4,
    SEL_B_Z1  = 4'd5,
    SEL_B_N0  = 4'd6,
    SEL_B_N1  = 4'd7,
    SEL_CFG_Z = 4'd8,
    SEL_CFG_N = 4'd9
  } tsbp_sel_e;
endpackage

// File: rtl/tsbp_regs.sv
module tsbp_regs
  import tsbp_pkg::*;
(
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic                                      wr_en,
  input  logic [SEL_W-1:0]                          wr_sel,
  input  logic [DATA_W-1:0]                         wr_data,
  output logic [DATA_W-1:0]                         tag_o,
  output logic [N_CLASS-1:0][N_SLOT-1:0][DATA_W-1:0] base_o,
  output logic [N_CLASS-1:0][DATA_W-1:0]            cfg_o
);
  logic [DATA_W-1:0] tag_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                          tag_q <= '0;
    else if (wr_en && wr_sel == SEL_TAG) tag_q <= wr_data;
  end
  assign tag_o = tag_q;

  for (genvar c = 0; c < N_CLASS; c++) begin : g_class
    localparam logic [SEL_W-1:0] CFG_CODE = SEL_W'(int'(SEL_CFG_Z) + c);
    logic [DATA_W-1:0] cfg_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                           cfg_q <= '0;
      else if (wr_en && wr_sel == CFG_CODE) cfg_q <= wr_data;
    end
    assign cfg_o[c] = cfg_q;

    for (genvar s = 0; s < N_SLOT; s++) begin : g_slot
      localparam logic [SEL_W-1:0] BASE_CODE = SEL_W'(int'(SEL_B_Z0) + N_SLOT*c + s);
      logic [DATA_W-1:0] base_q;
      always_ff @(posedge clk) begin
        if (!rst_n)                            base_q <= '0;
        else if (wr_en && wr_sel == BASE_CODE) base_q <= wr_data;
      end
      assign base_o[c][s] = base_q;
    end
  end

  AST_QUIET_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(tag_o) && $stable(cfg_o) && $stable(base_o))); // R10
endmodule

// File: rtl/tsbp_ptr_calc.sv
module tsbp_ptr_calc
  import tsbp_pkg::*;
#(
  parameter bit SPLIT_EN = 1'b0
) (
  input  logic [DATA_W-1:0]      tag_i,
  input  logic [DATA_W-1:VPN_LO] base_hi_i,
  input  logic                   split_i,
  input  logic [SZ_W-1:0]        sz_i,
  input  logic [PS_W-1:0]        ps_i,
  output logic [DATA_W-1:0]      ptr_o
);
  localparam int SH_W = 6;
  localparam logic [DATA_W-1:0] ONES = {DATA_W{1'b1}};

  logic [SH_W-1:0]   shamt;
  logic [SH_W-1:0]   idx_end;
  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] index;
  logic [DATA_W-1:0] dbl;

  always_comb begin
    shamt   = SH_W'(SHIFT_BASE) + SH_W'(ps_i) * SH_W'(SHIFT_STEP);
    idx_end = SH_W'(IDX_HI_BASE + 1) + SH_W'(sz_i);
    mask    = (ONES << IDX_LO) & ~(ONES << idx_end);
    index   = (tag_i >> shamt) & mask;
  end

  if (SPLIT_EN) begin : g_split
    assign dbl = split_i ? (DATA_W'(1) << idx_end) : '0;
  end else begin : g_plain
    assign dbl = {DATA_W{split_i}} & '0;
  end

  assign ptr_o = {base_hi_i, {VPN_LO{1'b0}}} | index | dbl;
endmodule

// File: rtl/tsbp_rsp.sv
module tsbp_rsp
  import tsbp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  logic accept;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_data  <= in_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R9
  AST_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid); // R8
endmodule

// File: rtl/tsbp_gen.sv
module tsbp_gen
  import tsbp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data
);
  logic [DATA_W-1:0]                         tag;
  logic [N_CLASS-1:0][N_SLOT-1:0][DATA_W-1:0] base;
  logic [N_CLASS-1:0][DATA_W-1:0]            cfg;
  logic [N_SLOT-1:0][DATA_W-1:0]             ptr;
  logic [DATA_W-1:0]                         tgt;
  logic [DATA_W-1:0]                         rd_mux;
  logic                                      cls;

  tsbp_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .tag_o(tag), .base_o(base), .cfg_o(cfg)
  );

  assign cls = (tag[CTX_W-1:0] != '0);

  for (genvar s = 0; s < N_SLOT; s++) begin : g_ptr
    tsbp_ptr_calc #(.SPLIT_EN(s == 1)) u_calc (
      .tag_i    (tag),
      .base_hi_i(base[cls][s][DATA_W-1:VPN_LO]),
      .split_i  (base[cls][s][SPLIT_BIT]),
      .sz_i     (base[cls][s][SZ_W-1:0]),
      .ps_i     (cfg[cls][PS_W-1:0]),
      .ptr_o    (ptr[s])
    );
  end

  always_comb begin
    tgt = '0;
    tgt[TGT_VA_W-1:0]            = tag[DATA_W-1:TGT_VA_LO];
    tgt[TGT_CTX_POS +: CTX_W]    = tag[CTX_W-1:0];
  end

  always_comb begin
    case (rd_sel)
      SEL_TAG:   rd_mux = tag;
      SEL_TGT:   rd_mux = tgt;
      SEL_PTR0:  rd_mux = ptr[0];
      SEL_PTR1:  rd_mux = ptr[1];
      SEL_B_Z0:  rd_mux = base[0][0];
      SEL_B_Z1:  rd_mux = base[0][1];
      SEL_B_N0:  rd_mux = base[1][0];
      SEL_B_N1:  rd_mux = base[1][1];
      SEL_CFG_Z: rd_mux = cfg[0];
      SEL_CFG_N: rd_mux = cfg[1];
      default:   rd_mux = '0;
    endcase
  end

  tsbp_rsp u_rsp (
    .clk(clk), .rst_n(rst_n),
    .in_valid(rd_valid), .in_ready(rd_ready), .in_data(rd_mux),
    .out_valid(rsp_valid), .out_ready(rsp_ready), .out_data(rsp_data)
  );

  AST_PTR_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr[0][IDX_LO-1:0] == '0) && (ptr[1][IDX_LO-1:0] == '0)); // R5
  AST_CTX_ZERO_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (tag[CTX_W-1:0] == '0) |-> (ptr[0][DATA_W-1:29] == base[0][0][DATA_W-1:29])); // R4
  AST_CTX_OTHER_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (tag[CTX_W-1:0] != '0) |-> (ptr[0][DATA_W-1:29] == base[1][0][DATA_W-1:29])); // R4
endmodule

// File: tb/sim_tsbp_gen.sv
module sim_tsbp_gen;
  import tsbp_pkg::*;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              wr_en;
  logic [SEL_W-1:0]  wr_sel;
  logic [DATA_W-1:0] wr_data;
  logic              rd_valid;
  logic              rd_ready;
  logic [SEL_W-1:0]  rd_sel;
  logic              rsp_valid;
  logic              rsp_ready;
  logic [DATA_W-1:0] rsp_data;

  always #4 clk = ~clk;

  tsbp_gen u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_sel(rd_sel),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  longint unsigned seed = 64'h1234_5678_9abc_def1;

  logic [63:0] m_tag;
  logic [63:0] m_cfg [2];
  logic [63:0] m_base [2][2];

  function automatic logic [63:0] next_rand();
    seed = seed * 64'd6364136223846793005 + 64'd1442695040888963407;
    return seed ^ (seed >> 29);
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_ptr(input logic [63:0] t, input logic [63:0] b,
                                          input logic [63:0] c, input bit slot1);
    int ps = int'(c[2:0]);
    int sz = int'(b[3:0]);
    logic [63:0] m = '0;
    logic [63:0] r;
    for (int i = 4; i <= 12 + sz; i++) m[i] = 1'b1;
    r = {b[63:13], 13'd0} | ((t >> (9 + 3 * ps)) & m);
    if (slot1 && b[12]) r[13 + sz] = 1'b1;
    return r;
  endfunction

  function automatic logic [63:0] exp_tgt(input logic [63:0] t);
    logic [63:0] r = '0;
    r[41:0]  = t[63:22];
    r[60:48] = t[12:0];
    return r;
  endfunction

  function automatic logic [63:0] model_read(input int code);
    int k = (m_tag[12:0] != 13'd0) ? 1 : 0;
    case (code)
      0: return m_tag;
      1: return exp_tgt(m_tag);
      2: return exp_ptr(m_tag, m_base[k][0], m_cfg[k], 1'b0);
      3: return exp_ptr(m_tag, m_base[k][1], m_cfg[k], 1'b1);
      4: return m_base[0][0];
      5: return m_base[0][1];
      6: return m_base[1][0];
      7: return m_base[1][1];
      8: return m_cfg[0];
      9: return m_cfg[1];
      default: return 64'd0;
    endcase
  endfunction

  task automatic wr(input int code, input logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = SEL_W'(code); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    case (code)
      0: m_tag = d;
      4: m_base[0][0] = d;
      5: m_base[0][1] = d;
      6: m_base[1][0] = d;
      7: m_base[1][1] = d;
      8: m_cfg[0] = d;
      9: m_cfg[1] = d;
      default: ;
    endcase
  endtask

  task automatic rd(input int code, output logic [63:0] d);
    @(negedge clk);
    rd_valid = 1'b1; rd_sel = SEL_W'(code);
    @(negedge clk);
    rd_valid = 1'b0;
    chk("R8 response valid one cycle after accept", 64'(rsp_valid), 64'd1);
    d = rsp_data;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R8 watchdog expired actual=hung expected=complete");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] d;
    logic [63:0] held;
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_data = '0;
    rd_valid = 1'b0; rd_sel = '0; rsp_ready = 1'b1;
    m_tag = '0;
    for (int c = 0; c < 2; c++) begin
      m_cfg[c] = '0;
      for (int s = 0; s < 2; s++) m_base[c][s] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk("R1 rsp_valid after reset", 64'(rsp_valid), 64'd0);
    chk("R1 rd_ready after reset", 64'(rd_ready), 64'd1);
    for (int code = 0; code < 16; code++) begin
      rd(code, d);
      chk($sformatf("R1 reset read code %0d", code), d, 64'd0);
    end

    // R2: write and read back every writable register
    for (int code = 0; code < 10; code++) begin
      if (code == 0 || code >= 4) begin
        wr(code, next_rand());
        rd(code, d);
        chk($sformatf("R2 readback code %0d", code), d, model_read(code));
      end
    end

    // R3: read-only and unmapped codes ignore writes
    for (int code = 1; code < 16; code++) begin
      if (code <= 3 || code >= 10) wr(code, next_rand());
    end
    for (int code = 0; code < 16; code++) begin
      rd(code, d);
      chk($sformatf("R3 state after ignored writes code %0d", code), d, model_read(code));
    end

    // R4 R5 R6 R7 R10: sweep context class, page-size code, size field, split bit
    for (int k = 0; k < 2; k++) begin
      for (int ps = 0; ps < 8; ps++) begin
        for (int sz = 0; sz < 16; sz++) begin
          for (int sp = 0; sp < 2; sp++) begin
            logic [63:0] r;
            logic [63:0] own0, own1, oth0, oth1;
            r = next_rand();
            own0 = {next_rand()};
            own0[12] = ~sp[0]; own0[3:0] = 4'(sz);
            own1 = next_rand();
            own1[12] = sp[0]; own1[3:0] = 4'(sz);
            oth0 = next_rand();
            oth0[3:0] = 4'(sz) ^ 4'd9;
            oth1 = next_rand();
            oth1[12] = ~sp[0]; oth1[3:0] = 4'(sz) ^ 4'd6;
            wr(4 + 2 * k, own0);
            wr(5 + 2 * k, own1);
            wr(6 - 2 * k, oth0);
            wr(7 - 2 * k, oth1);
            wr(8 + k, {next_rand()} & ~64'h7 | 64'(ps));
            wr(9 - k, {next_rand()} & ~64'h7 | 64'(ps ^ 5));
            wr(0, k == 1 ? {r[63:13], r[12:0] | 13'h1} : {r[63:13], 13'd0});
            rd(2, d);
            chk($sformatf("R4 R5 slot0 k=%0d ps=%0d sz=%0d", k, ps, sz), d, model_read(2));
            rd(3, d);
            chk($sformatf("R4 R6 slot1 k=%0d ps=%0d sz=%0d split=%0d", k, ps, sz, sp),
                d, model_read(3));
            if (sz == 15 && sp == 1) begin
              rd(1, d);
              chk("R7 tag target layout", d, model_read(1));
              rd(0, d);
              chk("R10 tag unchanged by reads", d, m_tag);
              rd(5 + 2 * k, d);
              chk("R10 base unchanged by reads", d, model_read(5 + 2 * k));
            end
          end
        end
      end
    end

    // R9: back-pressure holds the response, even across a register write
    @(negedge clk);
    rsp_ready = 1'b0;
    rd_valid = 1'b1; rd_sel = SEL_TAG;
    @(negedge clk);
    rd_valid = 1'b0;
    held = m_tag;
    chk("R8 response valid under stall", 64'(rsp_valid), 64'd1);
    chk("R9 data captured", rsp_data, held);
    chk("R9 rd_ready low while stalled", 64'(rd_ready), 64'd0);
    wr(0, ~held);
    repeat (3) @(negedge clk);
    chk("R9 valid held", 64'(rsp_valid), 64'd1);
    chk("R9 data held", rsp_data, held);
    chk("R9 rd_ready still low", 64'(rd_ready), 64'd0);
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R9 drained after ready", 64'(rsp_valid), 64'd0);
    rd(0, d);
    chk("R2 tag write during stall took effect", d, ~held);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule